// File: doc/BRIEF.md
# Redundant Parameter Page Validator

This block takes in a device parameter page that is stored as several redundant copies, and picks one copy that can be trusted. The copies come in one after another on a byte stream, with one byte on each beat where `in_valid` is high. Each byte is written into an internal copy store. At the same time, a streaming checker accumulates the signature and CRC of the copy that is arriving. When the last byte of a copy has been taken, that copy is either accepted or rejected. The first copy that is accepted ends the run at once. Any later bytes are then ignored.

If every copy is rejected, the block builds a reconstructed page. Each bit of that page is the majority vote of the three copies at the same bit position. The reconstructed page is written into a separate vote buffer and then passes through the same checker. The result is a pass/fail flag, the index of the chosen copy, and a flag that says the vote path was taken. A combinational read port returns bytes of the chosen copy, or of the reconstructed page. A `start` pulse clears the result and begins a new run.

Top module: `ppv_param_validator`

## Requirements
- R1: A page is accepted only if bytes 0 to 3 hold 0x4F, 0x4E, 0x46, 0x49 in that order. A page with a correct CRC but any other signature is rejected.
- R2: The CRC is 16 bits wide and is preset to 0x4F4E at byte 0 of each page. For each byte, the byte is XORed into bits 15:8, and then eight MSB-first shifts are done, XORing in 0x8005 whenever the bit shifted out is 1. The CRC covers bytes 0 to 253 only, so a change in byte 253 makes the page fail.
- R3: The expected CRC is stored little-endian, with the low byte at offset 254 and the high byte at offset 255. A page that holds it with the two bytes swapped is rejected.
- R4: Copies are judged in the order 0, 1, 2. The first copy that passes is reported with `pass`=1, `recovered`=0 and `sel_copy` set to its index.
- R5: The verdict on a copy is taken only after all 256 of its bytes have been taken. When copy k is selected, `done` is high in the cycle right after the beat that carries byte 255 of copy k.
- R6: If all three copies fail, the reconstructed page has each bit set exactly when at least 2 of the 3 copies have that bit set. If the reconstructed page passes R1 to R3, the result is `pass`=1 and `recovered`=1.
- R7: If the reconstructed page also fails, the result is `pass`=0 and `recovered`=1.
- R8: `rd_data` returns byte `rd_addr` of the selected copy when `recovered`=0, and byte `rd_addr` of the reconstructed page when `recovered`=1. It does so in the same cycle, with no clock edge in between.
- R9: `done` is a single-cycle pulse and is raised exactly once per run. After it, `pass`, `recovered`, `sel_copy` and the read-port contents stay unchanged, whatever arrives on the input, until `start`.
- R10: After reset, and in the cycle after `start`, `done`, `pass`, `recovered` and `sel_copy` are 0. A `start` given in the middle of a copy throws away the partial data, and collection begins again at copy 0, byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new run; clears the result |
| in_valid | input | 1 | `in_byte` carries a page byte this cycle |
| in_byte | input | 8 | Page byte stream, all copies in order, byte 0 of each copy first |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| pass | output | 1 | The selected or reconstructed page is valid |
| recovered | output | 1 | The majority-vote page was built and judged |
| sel_copy | output | 2 | Index of the accepted copy (0 when `recovered`) |
| rd_addr | input | 8 | Byte offset for the read port |
| rd_data | output | 8 | Byte at `rd_addr` of the selected or reconstructed page |

## Verification
Several directed patterns each target one cause of rejection. These are a copy with a bad signature but a correct CRC over that content, a copy with its CRC bytes swapped, a copy whose CRC was built from a zero preset, and a copy with one bit flipped in byte 253. In each case a later clean copy must be chosen, so each pattern separates one rule of R1 to R3 from the others. A second group decides between the two vote outcomes. Distinct single-bit flips in all three copies must give a reconstructed page that passes and reads back equal to the original. The same bit flipped in two copies must fail. Seeded random trials put zero to two flips into each copy, and the bench model judges them. The beat count at which `done` appears tells early or late verdicts apart, and a restart given in the middle of a copy shows that stale bytes are dropped.

// File: rtl/ppv_pkg.sv
package ppv_pkg;

  localparam logic [15:0] PPV_CRC_POLY = 16'h8005;

  typedef enum logic [1:0] {
    ST_LOAD = 2'd0,
    ST_VOTE = 2'd1,
    ST_DONE = 2'd2
  } ppv_state_e;

  // One byte through the CRC: byte into the upper half, then eight MSB-first shifts.
  function automatic logic [15:0] ppv_crc_step(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
    logic [15:0] r;
    r = crc_in ^ {data, 8'h00};
    for (int i = 0; i < 8; i++) begin
      if (r[15]) r = (r << 1) ^ PPV_CRC_POLY;
      else       r = r << 1;
    end
    return r;
  endfunction

  // Expected signature byte at offsets 0..3.
  function automatic logic [7:0] ppv_sig_char(input logic [1:0] pos);
    case (pos)
      2'd0:    return 8'h4F;
      2'd1:    return 8'h4E;
      2'd2:    return 8'h46;
      default: return 8'h49;
    endcase
  endfunction

endpackage

// File: rtl/ppv_page_check.sv
module ppv_page_check
  import ppv_pkg::*;
#(
  parameter int          PAGE_BYTES = 256,
  parameter logic [15:0] CRC_INIT   = 16'h4F4E,
  localparam int         AW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    data,
  output logic          last,
  output logic          page_ok
);

  localparam logic [AW-1:0] LAST_IDX = AW'(PAGE_BYTES - 1);
  localparam logic [AW-1:0] CRC_LO   = AW'(PAGE_BYTES - 2);
  localparam logic [AW-1:0] SIG_LEN  = AW'(4);

  logic [15:0] crc_q, crc_base, crc_d;
  logic        sig_q, sig_base, sig_d;
  logic [7:0]  exp_lo_q;
  logic        first;

  assign first    = (idx == '0);
  assign crc_base = first ? CRC_INIT : crc_q;
  assign crc_d    = ppv_crc_step(crc_base, data);
  assign sig_base = first ? 1'b1 : sig_q;
  assign sig_d    = sig_base & ((idx >= SIG_LEN) || (data == ppv_sig_char(idx[1:0])));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q    <= '0;
      sig_q    <= 1'b0;
      exp_lo_q <= '0;
    end else if (en) begin
      if (idx < CRC_LO) crc_q <= crc_d;
      sig_q <= sig_d;
      if (idx == CRC_LO) exp_lo_q <= data;
    end
  end

  assign last    = en && (idx == LAST_IDX);
  assign page_ok = sig_q && (crc_q == {data, exp_lo_q});

endmodule

// File: rtl/ppv_copy_store.sv
module ppv_copy_store #(
  parameter int PAGE_BYTES = 256,
  parameter int NUM_COPIES = 3,
  localparam int AW = $clog2(PAGE_BYTES),
  localparam int CW = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [CW-1:0]               wr_copy,
  input  logic [AW-1:0]               wr_idx,
  input  logic [7:0]                  wr_data,
  input  logic [AW-1:0]               tap_idx,
  output logic [NUM_COPIES-1:0][7:0]  taps,
  input  logic [CW-1:0]               rd_copy,
  input  logic [AW-1:0]               rd_idx,
  output logic [7:0]                  rd_data
);

  logic [7:0] mem [NUM_COPIES][PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_copy][wr_idx] <= wr_data;
  end

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_tap
    assign taps[k] = mem[k][tap_idx];
  end

  assign rd_data = mem[rd_copy][rd_idx];

endmodule

// File: rtl/ppv_vote_unit.sv
module ppv_vote_unit #(
  parameter int PAGE_BYTES = 256,
  parameter int NUM_COPIES = 3,
  localparam int AW = $clog2(PAGE_BYTES)
) (
  input  logic                       clk,
  input  logic [NUM_COPIES-1:0][7:0] taps,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_idx,
  output logic [7:0]                 maj_byte,
  input  logic [AW-1:0]              rd_idx,
  output logic [7:0]                 rd_data
);

  localparam int HALF = NUM_COPIES / 2;

  logic [7:0] vbuf [PAGE_BYTES];

  for (genvar b = 0; b < 8; b++) begin : g_bit
    always_comb begin
      int ones;
      ones = 0;
      for (int k = 0; k < NUM_COPIES; k++) ones += int'(taps[k][b]);
      maj_byte[b] = (ones > HALF);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) vbuf[wr_idx] <= maj_byte;
  end

  assign rd_data = vbuf[rd_idx];

endmodule

// File: rtl/ppv_param_validator.sv
module ppv_param_validator
  import ppv_pkg::*;
#(
  parameter int          PAGE_BYTES = 256,
  parameter int          NUM_COPIES = 3,
  parameter logic [15:0] CRC_INIT   = 16'h4F4E,
  localparam int         AW         = $clog2(PAGE_BYTES),
  localparam int         CW         = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          done,
  output logic          pass,
  output logic          recovered,
  output logic [CW-1:0] sel_copy,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam logic [CW-1:0] LAST_COPY = CW'(NUM_COPIES - 1);

  ppv_state_e    state_q;
  logic [CW-1:0] copy_q;
  logic [AW-1:0] idx_q;
  logic          done_q, pass_q, rec_q;
  logic [CW-1:0] sel_q;

  // Named internal events (also observed by the bound checker).
  logic beat_taken, vote_step, chk_en, page_last, page_ok, result_held;
  logic [7:0] chk_data, maj_byte, copy_rd, vote_rd;
  logic [NUM_COPIES-1:0][7:0] taps;

  assign beat_taken  = (state_q == ST_LOAD) && in_valid && !start;
  assign vote_step   = (state_q == ST_VOTE) && !start;
  assign chk_en      = beat_taken || vote_step;
  assign chk_data    = (state_q == ST_VOTE) ? maj_byte : in_byte;
  assign result_held = (state_q == ST_DONE);

  ppv_page_check #(.PAGE_BYTES(PAGE_BYTES), .CRC_INIT(CRC_INIT)) u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (chk_en),
    .idx     (idx_q),
    .data    (chk_data),
    .last    (page_last),
    .page_ok (page_ok)
  );

  ppv_copy_store #(.PAGE_BYTES(PAGE_BYTES), .NUM_COPIES(NUM_COPIES)) u_store (
    .clk     (clk),
    .wr_en   (beat_taken),
    .wr_copy (copy_q),
    .wr_idx  (idx_q),
    .wr_data (in_byte),
    .tap_idx (idx_q),
    .taps    (taps),
    .rd_copy (sel_q),
    .rd_idx  (rd_addr),
    .rd_data (copy_rd)
  );

  ppv_vote_unit #(.PAGE_BYTES(PAGE_BYTES), .NUM_COPIES(NUM_COPIES)) u_vote (
    .clk      (clk),
    .taps     (taps),
    .wr_en    (vote_step),
    .wr_idx   (idx_q),
    .maj_byte (maj_byte),
    .rd_idx   (rd_addr),
    .rd_data  (vote_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      copy_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      rec_q   <= 1'b0;
      sel_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state_q <= ST_LOAD;
        copy_q  <= '0;
        idx_q   <= '0;
        pass_q  <= 1'b0;
        rec_q   <= 1'b0;
        sel_q   <= '0;
      end else begin
        case (state_q)
          ST_LOAD: begin
            if (beat_taken) begin
              if (page_last) begin
                idx_q <= '0;
                if (page_ok) begin
                  state_q <= ST_DONE;
                  done_q  <= 1'b1;
                  pass_q  <= 1'b1;
                  sel_q   <= copy_q;
                end else if (copy_q == LAST_COPY) begin
                  state_q <= ST_VOTE;
                end else begin
                  copy_q <= copy_q + 1'b1;
                end
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          ST_VOTE: begin
            if (page_last) begin
              state_q <= ST_DONE;
              done_q  <= 1'b1;
              pass_q  <= page_ok;
              rec_q   <= 1'b1;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done      = done_q;
  assign pass      = pass_q;
  assign recovered = rec_q;
  assign sel_copy  = sel_q;
  assign rd_data   = rec_q ? vote_rd : copy_rd;

endmodule

// File: rtl/ppv_sva.sv
module ppv_sva #(
  parameter int PAGE_BYTES = 256,
  parameter int NUM_COPIES = 3,
  localparam int CW = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          pass,
  input logic          recovered,
  input logic [CW-1:0] sel_copy,
  input logic          beat_taken,
  input logic          result_held
);

  logic [31:0] beat_cnt;
  logic        done_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt  <= '0;
      done_seen <= 1'b0;
    end else if (start) begin
      beat_cnt  <= '0;
      done_seen <= 1'b0;
    end else begin
      if (beat_taken) beat_cnt <= beat_cnt + 32'd1;
      if (done)       done_seen <= 1'b1;
    end
  end

  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !done_seen); // R9

  AST_SELECT_AT_COPY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !recovered) |-> (beat_cnt == 32'((int'(sel_copy) + 1) * PAGE_BYTES))); // R4

  AST_NO_EARLY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (beat_cnt >= 32'(PAGE_BYTES))); // R5

  AST_VOTE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && recovered) |-> (beat_cnt == 32'(NUM_COPIES * PAGE_BYTES))); // R6

  AST_FAIL_ONLY_VOTED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> recovered); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (result_held && !start) |=> ($stable(pass) && $stable(recovered) && $stable(sel_copy))); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !pass && !recovered && (sel_copy == '0))); // R10

endmodule

bind ppv_param_validator ppv_sva #(
  .PAGE_BYTES(PAGE_BYTES),
  .NUM_COPIES(NUM_COPIES)
) u_ppv_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .done        (done),
  .pass        (pass),
  .recovered   (recovered),
  .sel_copy    (sel_copy),
  .beat_taken  (beat_taken),
  .result_held (result_held)
);

// File: tb/tb_ppv_param_validator.sv
`timescale 1ns/1ps
module tb_ppv_param_validator;

  localparam int PB = 256;
  localparam int NC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       done, pass, recovered;
  logic [1:0] sel_copy;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  ppv_param_validator dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .done(done), .pass(pass), .recovered(recovered), .sel_copy(sel_copy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int beats_sent = 0;
  int beats_at_done = -1;

  logic [7:0] refp [PB];
  logic [7:0] cp   [NC][PB];
  logic [7:0] vp   [PB];

  always @(negedge clk) begin
    if (rst_n && done) begin
      done_cnt++;
      beats_at_done = beats_sent;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Page selector: 0..2 copies, 3 vote page, 4 reference.
  function automatic logic [7:0] pbyte(input int k, input int i);
    if (k < NC)  return cp[k][i];
    if (k == NC) return vp[i];
    return refp[i];
  endfunction

  // Bit-serial CRC model.
  function automatic logic [15:0] crc_of(input int k, input logic [15:0] init);
    logic [15:0] c;
    logic fb;
    c = init;
    for (int i = 0; i < PB - 2; i++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = c[15] ^ pbyte(k, i)[b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h8005;
      end
    end
    return c;
  endfunction

  function automatic bit page_good(input int k);
    bit sig;
    sig = (pbyte(k,0) == "O") && (pbyte(k,1) == "N") && (pbyte(k,2) == "F") && (pbyte(k,3) == "I");
    return sig && (crc_of(k, 16'h4F4E) == {pbyte(k, PB-1), pbyte(k, PB-2)});
  endfunction

  task automatic seal_copy(input int k, input logic [15:0] init);
    logic [15:0] c;
    c = crc_of(k, init);
    cp[k][PB-2] = c[7:0];
    cp[k][PB-1] = c[15:8];
  endtask

  task automatic build_ref();
    logic [15:0] c;
    for (int i = 0; i < PB; i++) refp[i] = 8'($urandom);
    refp[0] = "O"; refp[1] = "N"; refp[2] = "F"; refp[3] = "I";
    c = crc_of(4, 16'h4F4E);
    refp[PB-2] = c[7:0];
    refp[PB-1] = c[15:8];
    for (int k = 0; k < NC; k++)
      for (int i = 0; i < PB; i++) cp[k][i] = refp[i];
  endtask

  task automatic flip(input int k, input int i, input int b);
    cp[k][i][b] = ~cp[k][i][b];
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    @(negedge clk); in_valid = 1'b1; in_byte = v;
    @(posedge clk); beats_sent++;
  endtask

  task automatic run_trial(input string req);
    int exp_sel, exp_beats, base, wait_c, bad;
    bit exp_pass, exp_rec;
    pulse_start();
    check(!pass && !recovered && !done && sel_copy == 0, "R10", "cleared after start",
          int'({pass, recovered, done}), 0);
    exp_sel = -1;
    for (int k = 0; k < NC; k++) if (exp_sel < 0 && page_good(k)) exp_sel = k;
    for (int i = 0; i < PB; i++)
      vp[i] = (cp[0][i] & cp[1][i]) | (cp[0][i] & cp[2][i]) | (cp[1][i] & cp[2][i]);
    exp_rec   = (exp_sel < 0);
    exp_pass  = exp_rec ? page_good(NC) : 1'b1;
    exp_beats = exp_rec ? NC * PB : (exp_sel + 1) * PB;
    base = done_cnt;
    beats_sent = 0;
    beats_at_done = -1;
    for (int k = 0; k < NC; k++)
      for (int i = 0; i < PB; i++) send_byte(cp[k][i]);
    @(negedge clk); in_valid = 1'b0;
    wait_c = 0;
    while (done_cnt == base && wait_c < 400) begin @(negedge clk); wait_c++; end
    repeat (3) @(negedge clk);
    check(done_cnt - base == 1, "R9", "done pulses", done_cnt - base, 1);
    check(beats_at_done == exp_beats, "R5", "beats before done", beats_at_done, exp_beats);
    check(pass == exp_pass, req, "pass", int'(pass), int'(exp_pass));
    check(recovered == exp_rec, exp_rec ? "R6" : "R4", "recovered", int'(recovered), int'(exp_rec));
    if (!exp_rec)
      check(int'(sel_copy) == exp_sel, "R4", "sel_copy", int'(sel_copy), exp_sel);
    bad = 0;
    for (int a = 0; a < PB; a++) begin
      @(negedge clk); rd_addr = 8'(a);
      #1;
      if (rd_data != pbyte(exp_rec ? NC : exp_sel, a)) bad++;
    end
    check(bad == 0, "R8", "read port mismatches", bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int junk;
    junk = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !pass && !recovered && sel_copy == 0, "R10", "reset state",
          int'({done, pass, recovered, sel_copy}), 0);

    // Clean pages: copy 0 wins, copies 1 and 2 garbage after done are ignored (R9).
    build_ref();
    flip(1, 40, 2); flip(2, 0, 7);
    run_trial("R4");

    // R3: swapped CRC bytes in copy 0, copy 1 clean.
    build_ref();
    while (refp[PB-2] == refp[PB-1]) begin
      refp[10] = refp[10] + 8'd1;
      for (int i = 0; i < PB; i++) cp[0][i] = refp[i];
      seal_copy(0, 16'h4F4E);
      build_ref_fix();
    end
    cp[0][PB-2] = refp[PB-1]; cp[0][PB-1] = refp[PB-2];
    run_trial("R3");

    // R1: copy 0 wrong signature with CRC valid for its content; copy 1 corrupt; copy 2 clean.
    build_ref();
    cp[0][2] = "G"; seal_copy(0, 16'h4F4E);
    flip(1, 30, 4);
    run_trial("R1");

    // R2: copy 0 sealed with a zero preset, copy 1 flipped in byte 253, copy 2 clean.
    build_ref();
    seal_copy(0, 16'h0000);
    flip(1, PB-3, 0);
    run_trial("R2");

    // R6: distinct flips in every copy, vote recovers.
    build_ref();
    flip(0, 100, 3); flip(1, 7, 0); flip(2, PB-2, 5);
    run_trial("R6");

    // R7: same bit flipped in two copies, vote fails.
    build_ref();
    flip(0, 50, 2); flip(1, 50, 2); flip(2, 9, 1);
    run_trial("R7");

    // R10: restart in the middle of a copy, then a clean run.
    pulse_start();
    for (int i = 0; i < 100; i++) send_byte(8'($urandom));
    @(negedge clk); in_valid = 1'b0;
    build_ref();
    run_trial("R10");

    // Seeded random trials.
    for (int t = 0; t < 8; t++) begin
      build_ref();
      for (int k = 0; k < NC; k++) begin
        int nf;
        nf = int'($urandom_range(0, 2));
        for (int f = 0; f < nf; f++) flip(k, int'($urandom_range(0, PB-1)), int'($urandom_range(0, 7)));
      end
      run_trial("R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // Re-derive the reference CRC after an adjustment to refp.
  task automatic build_ref_fix();
    logic [15:0] c;
    c = crc_of(4, 16'h4F4E);
    refp[PB-2] = c[7:0];
    refp[PB-1] = c[15:8];
    for (int k = 0; k < NC; k++)
      for (int i = 0; i < PB; i++) cp[k][i] = refp[i];
  endtask

endmodule